// File: doc/BRIEF.md
# Two-Mode Banked Address Mapper

This block turns a 16-bit processor address into a physical page number, a RAM/flash flag and a 14-bit offset. The processor space is cut into four 16 KB windows, chosen by the top two address bits. Three page registers (bank A, bank B and a high-RAM page) and a one-bit mapping mode are loaded through a small write port. The mode picks one of two window layouts. In the alternate layout both banks move up one window, and bank A is split into a forced even/odd page pair that covers two adjacent windows.

A page register value is eight bits. Its top bit marks a RAM page; a clear top bit marks a flash page. The remaining bits form the page number on the output. The decode is purely combinational from the address and the registers, so a register write is visible on the first access after the clock edge that takes it. A parameter builds a legacy variant. That variant has a fixed RAM page 0 in the top window and no odd/even pairing.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous active-low reset the mode is 0 and all three page registers read as 0. Every window then maps flash page 0, except that the legacy variant maps RAM page 0 (flag 1, page 0) at C000h–FFFFh.
- R2: Addresses 0000h–3FFFh map flash page 0 (flag 0, page 0) in both modes, whatever the page registers hold.
- R3: In mode 0, 4000h–7FFFh maps the bank A register and 8000h–BFFFh maps the bank B register.
- R4: In mode 0, C000h–FFFFh maps the high-RAM page register. The legacy variant maps RAM page 0 there instead.
- R5: In mode 1, 4000h–7FFFh maps bank A with bit 0 forced to 0, and 8000h–BFFFh maps bank A with bit 0 forced to 1. C000h–FFFFh maps bank B. In the legacy variant 8000h–BFFFh maps bank A unchanged.
- R6: The offset output always equals address bits 13:0.
- R7: The RAM flag output is bit 7 of the mapped page value, and the page output is bits 6:0 of that value.
- R8: A control write sets the mode from data bit 0 alone. Data bits 1–7 have no effect on any mapping.
- R9: A write changes the mapping seen by the first access after the clock edge that accepts it. With the write enable low, no register changes, whatever the select and data inputs hold.
- R10: The write select code picks the target register: 0 = control, 1 = bank A, 2 = bank B, 3 = high-RAM page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel | input | 2 | Target register code (R10) |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | Processor address |
| map_page | output | 7 | Physical page number |
| map_is_ram | output | 1 | 1 = RAM page, 0 = flash page |
| map_offset | output | 14 | Offset inside the page |

## Verification
Page, flag and offset depend combinationally on the address, so an address change is checked 1 ns after it is driven, with no clock edge between. A register write is driven at a falling edge and taken on the following rising edge. The bench checks its effect at the next falling edge, which is the first access after the write and shows that no extra delay exists. Ignored writes are held across a full rising edge before the windows are read back. Two instances, one default and one legacy, see the same stimulus, and each is compared against a bench model.

// File: rtl/bank_map_pkg.sv
// Package: shared codes for the banked address mapper.
// Assumes: the write select field is two bits wide.
package bank_map_pkg;
    // Write target codes (R10)
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_BANKA = 2'd1,
        REG_BANKB = 2'd2,
        REG_HIGH  = 2'd3
    } reg_sel_e;

    // 16 KB window index taken from the top address bits
    typedef enum logic [1:0] {
        WIN_BOOT = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_MID  = 2'd2,
        WIN_TOP  = 2'd3
    } window_e;
endpackage

// File: rtl/bank_map_regs.sv
// Module: bank_map_regs
// Holds the mode bit and the three page registers loaded through a
// single write port. Assumes a synchronous active-low reset, and that only
// bit 0 of a control write has meaning for this block.
module bank_map_regs
    import bank_map_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    output logic              mode,
    output logic [PAGE_W-1:0] bank_a,
    output logic [PAGE_W-1:0] bank_b,
    output logic [PAGE_W-1:0] high_pg
);
    // Register update: reset to zero, else load the selected target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= 1'b0;
            bank_a  <= '0;
            bank_b  <= '0;
            high_pg <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                REG_CTRL:  mode    <= wr_data[0];
                REG_BANKA: bank_a  <= wr_data;
                REG_BANKB: bank_b  <= wr_data;
                REG_HIGH:  high_pg <= wr_data;
                default:   mode    <= mode;
            endcase
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode) && $stable(bank_a) && $stable(bank_b) && $stable(high_pg)));

    assert_ctrl_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_CTRL) |=> (mode == $past(wr_data[0]) && $stable(bank_a)));

    assert_banka_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_BANKA) |=> (bank_a == $past(wr_data) && $stable(mode)));
endmodule

// File: rtl/bank_map_decode.sv
// Module: bank_map_decode
// Combinational window decode: selects the page value for the window the
// address falls in, according to the mode. LEGACY builds the variant with
// a fixed RAM page at the top window and no odd/even pairing.
// Assumes: the top bit of a page value is the RAM flag.
module bank_map_decode
    import bank_map_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter bit LEGACY = 1'b0,
    parameter int OFF_W  = 14
) (
    input  logic [OFF_W+1:0]  addr,
    input  logic              mode,
    input  logic [PAGE_W-1:0] bank_a,
    input  logic [PAGE_W-1:0] bank_b,
    input  logic [PAGE_W-1:0] high_pg,
    output logic [PAGE_W-1:0] page_val,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [PAGE_W-1:0] RAM_PAGE0 = {1'b1, {(PAGE_W-1){1'b0}}};
    localparam logic [PAGE_W-1:0] ROM_PAGE0 = '0;

    logic [PAGE_W-1:0] a_even;
    logic [PAGE_W-1:0] a_odd;
    logic [PAGE_W-1:0] top_m0;
    logic [PAGE_W-1:0] mid_m1;

    assign a_even = {bank_a[PAGE_W-1:1], 1'b0};
    assign a_odd  = {bank_a[PAGE_W-1:1], 1'b1};

    // Variant choice: fixed top page and unpaired bank A for legacy builds
    generate
        if (LEGACY) begin : g_legacy
            assign top_m0 = RAM_PAGE0;
            assign mid_m1 = bank_a;
        end else begin : g_paired
            assign top_m0 = high_pg;
            assign mid_m1 = a_odd;
        end
    endgenerate

    // Window select: pick the page value for the addressed window
    always_comb begin
        case (window_e'(addr[OFF_W+1:OFF_W]))
            WIN_BOOT: page_val = ROM_PAGE0;
            WIN_LOW:  page_val = mode ? a_even : bank_a;
            WIN_MID:  page_val = mode ? mid_m1 : bank_b;
            WIN_TOP:  page_val = mode ? bank_b : top_m0;
            default:  page_val = ROM_PAGE0;
        endcase
    end

    assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/bank_mapper.sv
// Module: bank_mapper (top)
// Banked address mapper: register file plus window decode. The outputs
// follow the address combinationally; register writes apply from the next
// clock edge. Assumes a synchronous active-low reset and that page values
// carry the RAM flag in their top bit.
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter bit LEGACY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic [15:0]       cpu_addr,
    output logic [PAGE_W-2:0] map_page,
    output logic              map_is_ram,
    output logic [13:0]       map_offset
);
    localparam int OFF_W = 14;

    logic              mode;
    logic [PAGE_W-1:0] bank_a;
    logic [PAGE_W-1:0] bank_b;
    logic [PAGE_W-1:0] high_pg;
    logic [PAGE_W-1:0] page_val;
    logic [1:0]        win;

    bank_map_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mode    (mode),
        .bank_a  (bank_a),
        .bank_b  (bank_b),
        .high_pg (high_pg)
    );

    bank_map_decode #(.PAGE_W(PAGE_W), .LEGACY(LEGACY), .OFF_W(OFF_W)) u_dec (
        .addr     (cpu_addr),
        .mode     (mode),
        .bank_a   (bank_a),
        .bank_b   (bank_b),
        .high_pg  (high_pg),
        .page_val (page_val),
        .offset   (map_offset)
    );

    // Output split: RAM flag from the top bit, page number from the rest
    assign map_is_ram = page_val[PAGE_W-1];
    assign map_page   = page_val[PAGE_W-2:0];
    assign win        = cpu_addr[15:14];

    assert_boot_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_BOOT) |-> (map_page == '0 && !map_is_ram));

    assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        map_offset == cpu_addr[13:0]);

    assert_mode0_banka_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && win == WIN_LOW) |-> ({map_is_ram, map_page} == bank_a));

    generate
        if (!LEGACY) begin : g_pair_chk
            assert_even_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode && win == WIN_LOW) |-> (map_page[0] == 1'b0));
            assert_odd_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode && win == WIN_MID) |-> (map_page[0] == 1'b1));
        end
    endgenerate
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
// Bench for bank_mapper: a default and a legacy instance share stimulus;
// both are compared against a bench model of the requirements.
module tb_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [15:0] cpu_addr = 16'd0;
    logic [6:0]  pg_n, pg_l;
    logic        ram_n, ram_l;
    logic [13:0] off_n, off_l;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model state
    logic       m_mode = 1'b0;
    logic [7:0] m_a = 8'd0, m_b = 8'd0, m_h = 8'd0;

    always #2.5 clk = ~clk;

    bank_mapper #(.PAGE_W(8), .LEGACY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .map_page(pg_n), .map_is_ram(ram_n), .map_offset(off_n));

    bank_mapper #(.PAGE_W(8), .LEGACY(1'b1)) dut_legacy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .map_page(pg_l), .map_is_ram(ram_l), .map_offset(off_l));

    // Expected page value {flag, page} from the requirements R2..R5
    function automatic logic [7:0] exp_page(input logic [15:0] a, input logic m,
                                            input logic [7:0] ba, input logic [7:0] bb,
                                            input logic [7:0] hp, input bit leg);
        case (a[15:14])
            2'd0:    return 8'h00;
            2'd1:    return m ? (ba & 8'hFE) : ba;
            2'd2:    return m ? (leg ? ba : (ba | 8'h01)) : bb;
            default: return m ? bb : (leg ? 8'h80 : hp);
        endcase
    endfunction

    task automatic check_addr(input logic [15:0] a, input string req);
        logic [7:0] en, el;
        cpu_addr = a;
        #1;
        en = exp_page(a, m_mode, m_a, m_b, m_h, 1'b0);
        el = exp_page(a, m_mode, m_a, m_b, m_h, 1'b1);
        n_tests++;
        if ({ram_n, pg_n} !== en || off_n !== a[13:0]) begin
            n_fail++;
            $display("FAIL %s R6 R7 addr=%h: got page=%h off=%h, expected page=%h off=%h",
                     req, a, {ram_n, pg_n}, off_n, en, a[13:0]);
        end
        n_tests++;
        if ({ram_l, pg_l} !== el || off_l !== a[13:0]) begin
            n_fail++;
            $display("FAIL %s legacy addr=%h: got page=%h off=%h, expected page=%h off=%h",
                     req, a, {ram_l, pg_l}, off_l, el, a[13:0]);
        end
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 4; w++)
            check_addr({w[1:0], 14'($urandom)}, req);
    endtask

    // Write through the port (R10): driven at a falling edge, taken at the rising one
    task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0:    m_mode = d[0];
            2'd1:    m_a = d;
            2'd2:    m_b = d;
            default: m_h = d;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_mode = 1'b0; m_a = 8'd0; m_b = 8'd0; m_h = 8'd0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R1: reset state
        check_addr(16'h0123, "R1");
        check_addr(16'h4567, "R1");
        check_addr(16'h89AB, "R1");
        check_addr(16'hCDEF, "R1");

        // R3 R4 R10: each register via its select code, mode 0
        do_write(2'd1, 8'h85);
        do_write(2'd2, 8'h13);
        do_write(2'd3, 8'h81);
        check_addr(16'h4000, "R3 R10");
        check_addr(16'h8000, "R3 R10");
        check_addr(16'hFFFF, "R4 R10");
        check_addr(16'h3FFF, "R2");

        // R8: control write with only upper bits set leaves mode 0
        do_write(2'd0, 8'hFE);
        check_all("R8");

        // R5 R9: mode 1, checked on the first access after the write
        do_write(2'd0, 8'h01);
        check_addr(16'h8001, "R5 R9");
        check_addr(16'h7FFF, "R5");
        check_addr(16'hC000, "R5");
        check_addr(16'h0000, "R2");

        // R5: even bank A value in mode 1
        do_write(2'd1, 8'h06);
        check_all("R5");

        // R9: write enable low ignores select and data
        @(negedge clk);
        wr_sel = 2'd1; wr_data = 8'hFF;
        @(negedge clk);
        wr_sel = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        check_all("R9");

        // R8: control write with bit 0 set and others set
        do_write(2'd0, 8'h77);
        check_all("R8");
        do_write(2'd0, 8'h76);
        check_all("R8");

        // Random mix of writes and accesses
        for (int i = 0; i < 400; i++) begin
            do_write(2'($urandom), 8'($urandom));
            check_addr(16'($urandom), "R3 R4 R5 R7");
        end

        // R1: reset after activity
        do_write(2'd0, 8'h01);
        do_reset();
        check_addr(16'h4ABC, "R1");
        check_addr(16'h9ABC, "R1");
        check_addr(16'hE000, "R1");

        finish_run();
    end
endmodule